// File: doc/BRIEF.md
# Byte-Lane Write Strobe Controller

This block turns the active-low write controls of a synchronous memory port into registered per-lane write strobes. The memory word is divided into lanes of nine bits: eight data bits and one parity bit. A global write input, when asserted, writes the whole word. Otherwise a byte-write gate decides whether the individual lane selects are passed on or blocked. All controls are sampled on the rising clock edge. The decoded strobes are held in registers, so they line up with input data that is registered on the same edge.

Besides the per-lane strobe vector, the block produces two further outputs. The first is a write flag that the output-driver logic uses to turn the data drivers off during a write. The second is the lane strobes expanded to one enable per data bit and one per parity bit, ready for the array's write drivers. The lane count is a parameter, either 2 or 4. The lane-select input is always four bits wide; in the 2-lane build its two upper bits are unused.

Top module: `byte_lane_wr_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all outputs are 0 after that edge, whatever the write controls are.
- R2: If `gwr_n` is 0 at a rising edge, every lane strobe is 1 after that edge, regardless of `bgate_n` and `lane_sel_n`.
- R3: If `gwr_n` is 1 and `bgate_n` is 1 at a rising edge, no lane strobe is set and `is_write` is 0, whatever `lane_sel_n` holds.
- R4: If `gwr_n` is 1 and `bgate_n` is 0 at a rising edge, lane strobe i (bit i of `lane_we`) equals the inverse of `lane_sel_n[i]`, and any combination of lanes may be set in the same cycle.
- R5: In the case of R4 with every used bit of `lane_sel_n` at 1, no strobe is set and `is_write` is 0 (read cycle).
- R6: `is_write` is 1 exactly when at least one bit of `lane_we` is 1. A 1 on `is_write` means the output drivers must be off.
- R7: Lane i maps to `data_bit_we` bits 8i to 8i+7 and to `par_bit_we` bit i. Each of those bits equals `lane_we[i]`.
- R8: All outputs are registered. Controls sampled at edge N appear after edge N and do not change the outputs before that edge.
- R9: With LANES=2, only `lane_sel_n[1:0]` has any effect, and `lane_sel_n[3:2]` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| gwr_n | input | 1 | Global write (whole word), active low |
| bgate_n | input | 1 | Gate that passes the lane selects, active low |
| lane_sel_n | input | 4 | Per-lane write selects, active low; bit i is lane i |
| lane_we | output | LANES | Registered per-lane write strobes, active high |
| is_write | output | 1 | Registered write-cycle flag; output drivers must be off while it is 1 |
| data_bit_we | output | 8*LANES | Per-data-bit write enables, lane i at bits 8i..8i+7 |
| par_bit_we | output | LANES | Per-parity-bit write enables, bit i for lane i |

## Verification
The global write and the lane-select path can be active in the same cycle. The bench provokes this by holding `gwr_n` low while `bgate_n` is low and a partial pattern sits on `lane_sel_n`. It judges the result by requiring every lane strobe and every bit enable to be set, not just the selected ones. A second clash is a synchronous reset arriving while the global write is held low; that case must end with all outputs cleared. A 2-lane instance runs the same vectors, with patterns whose two upper selects differ from the lower ones, to show the upper selects are ignored.

// File: rtl/lane_wr_pkg.sv
// Package: shared constants for the byte-lane write strobe controller.
// Assumes every lane carries a fixed count of data bits plus one parity bit.
package lane_wr_pkg;
    localparam int MAX_LANES  = 4;   // width of the lane-select port
    localparam int LANE_DBITS = 8;   // data bits per lane
    localparam int LANE_PBITS = 1;   // parity bits per lane
    localparam int LANE_WIDTH = LANE_DBITS + LANE_PBITS;

    // Cycle kind decided from the write controls
    typedef enum logic [1:0] {
        CYC_READ   = 2'd0,
        CYC_GLOBAL = 2'd1,
        CYC_LANES  = 2'd2
    } cyc_kind_t;
endpackage

// File: rtl/lane_wr_decode.sv
// Module: lane_wr_decode
// Combinational decode of the active-low write controls into per-lane
// strobes and a write flag. The global write overrides the lane path.
// The gate passes or blocks the lane selects.
// Assumes: the inputs are stable around the sampling clock edge (registered downstream).
module lane_wr_decode
    import lane_wr_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             gwr_n,
    input  logic             bgate_n,
    input  logic [LANES-1:0] sel_n,
    output logic [LANES-1:0] we,
    output logic             wr
);
    cyc_kind_t kind;

    // Classify the cycle by the two-level priority
    always_comb begin
        if (!gwr_n)        kind = CYC_GLOBAL;
        else if (!bgate_n) kind = CYC_LANES;
        else               kind = CYC_READ;
    end

    // Per-lane strobe selection
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            unique case (kind)
                CYC_GLOBAL: we[i] = 1'b1;
                CYC_LANES:  we[i] = ~sel_n[i];
                default:    we[i] = 1'b0;
            endcase
        end
    end

    // Write flag derived from the controls, independent of the lane loop
    always_comb begin
        wr = (kind == CYC_GLOBAL) || ((kind == CYC_LANES) && !(&sel_n));
    end
endmodule

// File: rtl/lane_wr_stage.sv
// Module: lane_wr_stage
// Register stage that aligns the decoded strobes and the write flag with
// input data registered on the same clock edge.
// Assumes a synchronous active-low reset.
module lane_wr_stage #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] we_d,
    input  logic             wr_d,
    output logic [LANES-1:0] we_q,
    output logic             wr_q
);
    // Capture the decoded strobes; reset clears them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q <= '0;
            wr_q <= 1'b0;
        end else begin
            we_q <= we_d;
            wr_q <= wr_d;
        end
    end
endmodule

// File: rtl/lane_bit_map.sv
// Module: lane_bit_map
// Expands the per-lane strobes into per-bit enables: lane i drives data bits
// DBITS*i .. DBITS*i+DBITS-1 and parity bit i.
// Assumes one parity bit per lane.
module lane_bit_map #(
    parameter int LANES = 4,
    parameter int DBITS = 8
) (
    input  logic [LANES-1:0]       lane_we,
    output logic [DBITS*LANES-1:0] data_we,
    output logic [LANES-1:0]       par_we
);
    // Fan each lane strobe out to its data and parity bits
    for (genvar i = 0; i < LANES; i++) begin : g_map
        assign data_we[DBITS*i +: DBITS] = {DBITS{lane_we[i]}};
        assign par_we[i]                 = lane_we[i];
    end
endmodule

// File: rtl/byte_lane_wr_ctrl.sv
// Module: byte_lane_wr_ctrl (top)
// Registered byte-lane write strobe controller for a word of 9-bit lanes.
// Assumes LANES is 2 or 4. The lane-select port is always MAX_LANES wide and
// its upper bits are unused when LANES is smaller.
module byte_lane_wr_ctrl
    import lane_wr_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        gwr_n,
    input  logic                        bgate_n,
    input  logic [MAX_LANES-1:0]        lane_sel_n,
    output logic [LANES-1:0]            lane_we,
    output logic                        is_write,
    output logic [LANE_DBITS*LANES-1:0] data_bit_we,
    output logic [LANES-1:0]            par_bit_we
);
    localparam int USED = LANES;

    logic [USED-1:0] sel_used_n;
    logic [USED-1:0] we_dec;
    logic            wr_dec;

    // Keep only the selects of lanes that exist
    assign sel_used_n = lane_sel_n[USED-1:0];

    if (USED < MAX_LANES) begin : g_spare
        logic unused_sel;
        assign unused_sel = ^lane_sel_n[MAX_LANES-1:USED];
    end

    lane_wr_decode #(.LANES(USED)) u_dec (
        .gwr_n   (gwr_n),
        .bgate_n (bgate_n),
        .sel_n   (sel_used_n),
        .we      (we_dec),
        .wr      (wr_dec)
    );

    lane_wr_stage #(.LANES(USED)) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .we_d  (we_dec),
        .wr_d  (wr_dec),
        .we_q  (lane_we),
        .wr_q  (is_write)
    );

    lane_bit_map #(.LANES(USED), .DBITS(LANE_DBITS)) u_map (
        .lane_we (lane_we),
        .data_we (data_bit_we),
        .par_we  (par_bit_we)
    );

    AST_GLOBAL_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        !gwr_n |=> (lane_we == {USED{1'b1}}));                                   // R2
    AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (gwr_n && bgate_n) |=> (!is_write && lane_we == '0));                    // R3
    AST_LANE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (gwr_n && !bgate_n) |=> (lane_we == ~$past(lane_sel_n[USED-1:0])));      // R4
    AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        is_write == (lane_we != '0));                                            // R6
    AST_PARITY_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        par_bit_we == lane_we);                                                  // R7
endmodule

// File: tb/sim_byte_lane_wr_ctrl.sv
// Bench for byte_lane_wr_ctrl: vector table walk, then directed tests.
module sim_byte_lane_wr_ctrl;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gwr_n = 1'b1;
    logic       bgate_n = 1'b1;
    logic [3:0] lane_sel_n = 4'hF;

    logic [3:0]  we4;
    logic        wr4;
    logic [31:0] dwe4;
    logic [3:0]  pwe4;
    logic [1:0]  we2;
    logic        wr2;
    logic [15:0] dwe2;
    logic [1:0]  pwe2;

    int errs = 0;
    int checks = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    byte_lane_wr_ctrl #(.LANES(4)) u0 (
        .clk(clk), .rst_n(rst_n), .gwr_n(gwr_n), .bgate_n(bgate_n),
        .lane_sel_n(lane_sel_n), .lane_we(we4), .is_write(wr4),
        .data_bit_we(dwe4), .par_bit_we(pwe4));

    byte_lane_wr_ctrl #(.LANES(2)) u1 (
        .clk(clk), .rst_n(rst_n), .gwr_n(gwr_n), .bgate_n(bgate_n),
        .lane_sel_n(lane_sel_n), .lane_we(we2), .is_write(wr2),
        .data_bit_we(dwe2), .par_bit_we(pwe2));

    // Entry layout: {gwr_n, bgate_n, lane_sel_n[3:0], expected 4-lane strobes[3:0]}
    localparam int NV = 11;
    localparam logic [9:0] VEC [NV] = '{
        10'b0_1_1111_1111,  // R2 global write, gate high
        10'b0_0_0101_1111,  // R2 global overrides partial lane selects
        10'b1_1_0000_0000,  // R3 gate blocks all selects
        10'b1_0_1110_0001,  // R4 single lane 0
        10'b1_0_0101_1010,  // R4 lanes 1 and 3
        10'b1_0_0000_1111,  // R4 all lanes by select
        10'b1_0_1111_0000,  // R5 gate low, no select
        10'b1_0_1001_0110,  // R4 middle lanes
        10'b1_1_1111_0000,  // R3 idle read
        10'b1_0_0011_1100,  // R4/R9 upper lanes only
        10'b1_0_1101_0010   // R4 lane 1 alone
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] expand(input logic [3:0] w, input int n);
        logic [31:0] r = '0;
        for (int i = 0; i < n; i++) r[8*i +: 8] = {8{w[i]}};
        return r;
    endfunction

    // Expected 2-lane strobes from the rules, using only selects 1:0
    function automatic logic [1:0] exp2(input logic g, input logic b, input logic [3:0] s);
        if (!g) return 2'b11;
        if (!b) return ~s[1:0];
        return 2'b00;
    endfunction

    task automatic check_all(input string tag, input logic [3:0] e4, input logic [1:0] e2);
        chk({tag, " R4 lane_we"}, {28'd0, we4}, {28'd0, e4});
        chk({tag, " R6 is_write"}, {31'd0, wr4}, {31'd0, |e4});
        chk({tag, " R7 data_bit_we"}, dwe4, expand(e4, 4));
        chk({tag, " R7 par_bit_we"}, {28'd0, pwe4}, {28'd0, e4});
        chk({tag, " R9 lane_we 2-lane"}, {30'd0, we2}, {30'd0, e2});
        chk({tag, " R6 is_write 2-lane"}, {31'd0, wr2}, {31'd0, |e2});
        chk({tag, " R7 data_bit_we 2-lane"}, {16'd0, dwe2}, expand({2'b00, e2}, 2));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_all("R1 reset", 4'h0, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: drive at a falling edge, check at the next one
        for (int v = 0; v < NV; v++) begin
            gwr_n      = VEC[v][9];
            bgate_n    = VEC[v][8];
            lane_sel_n = VEC[v][7:4];
            @(negedge clk);
            check_all($sformatf("vec%0d", v), VEC[v][3:0],
                      exp2(VEC[v][9], VEC[v][8], VEC[v][7:4]));
        end

        // R8: new controls must not reach the outputs before the next edge
        gwr_n = 1'b1; bgate_n = 1'b1; lane_sel_n = 4'hF;
        @(negedge clk);
        gwr_n = 1'b0;
        #1;
        chk("R8 no change before edge", {28'd0, we4}, 32'd0);
        @(negedge clk);
        chk("R8 visible after edge", {28'd0, we4}, 32'hF);

        // R1: synchronous reset wins over a held global write
        rst_n = 1'b0;
        @(negedge clk);
        check_all("R1 reset over global write", 4'h0, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R2 after reset release", 4'hF, 2'b11);

        // R5: read cycle right after a write cycle clears the flag
        gwr_n = 1'b1; bgate_n = 1'b0; lane_sel_n = 4'hF;
        @(negedge clk);
        check_all("R5 read after write", 4'h0, 2'b00);

        // R9: upper selects toggled alone leave the 2-lane instance idle
        lane_sel_n = 4'b0111;
        @(negedge clk);
        check_all("R9 top select only", 4'h8, 2'b00);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule